// File: doc/BRIEF.md
# Byte/Word Add-Subtract Unit with Flag Register

This block performs addition, addition with carry, subtraction, subtraction with borrow, comparison and negation on either 8-bit or 16-bit operands. It then updates an 8-bit flag register with half-carry, negative, zero, overflow and carry. One request is issued per cycle with `op_valid`. The result and the new flags are registered, so they appear on the ports one clock later.

The flag register can also be written directly, in the way software would write it. The write either loads a value or combines one into the register with an AND, OR or XOR mask. An exception-entry strobe forces the interrupt mask bit on. Reset sets that mask bit and leaves every other flag as it was. Byte results sit in the low eight bits of the result port, and the upper bits are zero.

Top module: `arith_flag_unit`

## Requirements
- R1: A synchronous reset sets flag bit 7 (interrupt mask) to 1, clears `result_valid` and sets `result` to zero. The other seven flag bits are not reset.
- R2: With `op_valid`, `op_sel` 0 (add) gives a+b and `op_sel` 1 (add with carry) gives a+b+`carry_in`. The result is truncated to the selected size. C (bit 0) is the carry out of the top bit. The result and flags appear one cycle later with `result_valid` set.
- R3: `op_sel` 2 (subtract) gives a−b and `op_sel` 3 (subtract with borrow) gives a−b−`carry_in`. C (bit 0) holds the borrow out of the top bit.
- R4: H (bit 5) is the carry or borrow out of bit 3 when `size_word` is 0, and out of bit 11 when `size_word` is 1.
- R5: N (bit 3) is the top bit of the selected size and Z (bit 2) is set exactly when that result is zero. For byte operations, `result[15:8]` is zero and the upper operand bits have no effect.
- R6: V (bit 1) is set on two's-complement overflow of the selected size and cleared otherwise.
- R7: `op_sel` 4 (compare) sets the flags as a subtract would, but leaves `result_valid` low and `result` unchanged.
- R8: `op_sel` 5 (negate) computes 0−`opb`, with flags as for a subtract. `opa` is ignored.
- R9: `op_sel` values 6 and 7, and cycles with `op_valid` low, change no flag and leave `result_valid` low.
- R10: Arithmetic never changes bit 7 (I) or the user bits 6 and 4.
- R11: With `ccr_wr`, `ccr_wr_mode` selects how `ccr_wr_data` is applied to all eight bits: 0 loads it, 1 ANDs it, 2 ORs it and 3 XORs it. The new value is visible next cycle. This write takes precedence over a flag update from a simultaneous operation, though that operation still produces its result.
- R12: `exc_entry` sets bit 7 next cycle, overriding a simultaneous write of 0 to that bit. The other bits still follow the write or the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_sel | input | 3 | Operation code (0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 compare, 5 negate) |
| size_word | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| carry_in | input | 1 | Carry or borrow input for codes 1 and 3 |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| ccr_wr | input | 1 | Direct write to the flag register |
| ccr_wr_mode | input | 2 | 0 load, 1 AND, 2 OR, 3 XOR |
| ccr_wr_data | input | 8 | Write value or mask |
| exc_entry | input | 1 | Exception-entry strobe, sets the interrupt mask |
| result | output | 16 | Registered result, zero-extended for bytes |
| result_valid | output | 1 | Result holds a write-back value from the last cycle |
| ccr | output | 8 | Flag register: I,U,H,U,N,Z,V,C from bit 7 down |

## Verification
The bench uses the default widths: a 16-bit word and an 8-bit byte. These widths place the half-carry taps at bits 3 and 11. That makes it possible to pick operands that carry out of bit 3 but not out of bit 11, and the reverse, so a wrong tap shows up in the H flag. The 8-bit lane inside a 16-bit port also lets the bench feed nonzero upper operand bits into byte operations and confirm that they never reach the result or the flags.

// File: rtl/afu_pkg.sv
package afu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBB = 3'd3,
    OP_CMP  = 3'd4,
    OP_NEG  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } afu_op_e;

  typedef enum logic [1:0] {
    WR_LOAD = 2'd0,
    WR_AND  = 2'd1,
    WR_OR   = 2'd2,
    WR_XOR  = 2'd3
  } ccr_wr_e;

  localparam int CCR_W  = 8;
  localparam int CCR_I  = 7;
  localparam int CCR_UH = 6;
  localparam int CCR_H  = 5;
  localparam int CCR_UL = 4;
  localparam int CCR_N  = 3;
  localparam int CCR_Z  = 2;
  localparam int CCR_V  = 1;
  localparam int CCR_C  = 0;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/afu_addsub.sv
module afu_addsub
  import afu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          sub,
  input  logic          cin,
  output logic [W-1:0]  sum,
  output arith_flags_t  flags
);
  // half-carry tap: carry out of bit W-5 (bit 3 for bytes, bit 11 for words)
  localparam int HB = W - 5;

  logic [W-1:0]  bx;
  logic          ci;
  logic [W:0]    full;
  logic [HB+1:0] low;

  always_comb begin
    bx   = sub ? ~b : b;
    ci   = sub ? ~cin : cin;
    full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
    low  = {1'b0, a[HB:0]} + {1'b0, bx[HB:0]} + {{(HB+1){1'b0}}, ci};
    sum  = full[W-1:0];
    flags.c = sub ? ~full[W] : full[W];
    flags.h = sub ? ~low[HB+1] : low[HB+1];
    flags.v = (a[W-1] == bx[W-1]) && (full[W-1] != a[W-1]);
    flags.n = full[W-1];
    flags.z = (full[W-1:0] == '0);
  end
endmodule

// File: rtl/afu_ccr.sv
module afu_ccr
  import afu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_mode,
  input  logic [CCR_W-1:0] wr_data,
  input  logic             upd_en,
  input  arith_flags_t     upd_flags,
  input  logic             exc,
  output logic [CCR_W-1:0] ccr
);
  logic [CCR_W-1:0] nxt;

  always_comb begin
    nxt = ccr;
    if (wr_en) begin
      unique case (ccr_wr_e'(wr_mode))
        WR_LOAD: nxt = wr_data;
        WR_AND:  nxt = ccr & wr_data;
        WR_OR:   nxt = ccr | wr_data;
        WR_XOR:  nxt = ccr ^ wr_data;
        default: nxt = ccr;
      endcase
    end else if (upd_en) begin
      nxt[CCR_H] = upd_flags.h;
      nxt[CCR_N] = upd_flags.n;
      nxt[CCR_Z] = upd_flags.z;
      nxt[CCR_V] = upd_flags.v;
      nxt[CCR_C] = upd_flags.c;
    end
    if (exc) nxt[CCR_I] = 1'b1;
  end

  // mask bit: the only flag with a reset value
  always_ff @(posedge clk) begin
    if (rst) ccr[CCR_I] <= 1'b1;
    else     ccr[CCR_I] <= nxt[CCR_I];
  end

  // remaining flags keep whatever they held through reset
  always_ff @(posedge clk) begin
    ccr[CCR_I-1:0] <= nxt[CCR_I-1:0];
  end

  // R12
  exc_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && exc) |=> ccr[CCR_I]);

  // R10
  user_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_en && !exc) |=>
      (ccr[CCR_I] == $past(ccr[CCR_I])) && (ccr[CCR_UH] == $past(ccr[CCR_UH]))
      && (ccr[CCR_UL] == $past(ccr[CCR_UL])));
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic              size_word,
  input  logic              carry_in,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              ccr_wr,
  input  logic [1:0]        ccr_wr_mode,
  input  logic [CCR_W-1:0]  ccr_wr_data,
  input  logic              exc_entry,
  output logic [WORD_W-1:0] result,
  output logic              result_valid,
  output logic [CCR_W-1:0]  ccr
);
  localparam int NSZ = 2;

  afu_op_e           op;
  logic              arith_op;
  logic              writes_back;
  logic              is_sub;
  logic              cin_eff;
  logic [WORD_W-1:0] a_eff;
  logic [WORD_W-1:0] sum_ext [NSZ];
  arith_flags_t      fl      [NSZ];
  logic [WORD_W-1:0] sel_sum;
  arith_flags_t      sel_fl;

  always_comb begin
    op          = afu_op_e'(op_sel);
    arith_op    = op_valid && (op_sel <= OP_NEG);
    writes_back = arith_op && (op != OP_CMP);
    is_sub      = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_CMP) || (op == OP_NEG);
    cin_eff     = ((op == OP_ADDC) || (op == OP_SUBB)) && carry_in;
    a_eff       = (op == OP_NEG) ? '0 : opa;
  end

  // one adder lane per operand size: index 0 byte, index 1 word
  for (genvar g = 0; g < NSZ; g++) begin : g_lane
    localparam int W = (g == 0) ? BYTE_W : WORD_W;
    logic [W-1:0] s;
    afu_addsub #(.W(W)) u_addsub (
      .a     (a_eff[W-1:0]),
      .b     (opb[W-1:0]),
      .sub   (is_sub),
      .cin   (cin_eff),
      .sum   (s),
      .flags (fl[g])
    );
    assign sum_ext[g] = WORD_W'(s);
  end

  assign sel_sum = size_word ? sum_ext[1] : sum_ext[0];
  assign sel_fl  = size_word ? fl[1] : fl[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= writes_back;
      if (writes_back) result <= sel_sum;
    end
  end

  afu_ccr u_ccr (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ccr_wr),
    .wr_mode   (ccr_wr_mode),
    .wr_data   (ccr_wr_data),
    .upd_en    (arith_op),
    .upd_flags (sel_fl),
    .exc       (exc_entry),
    .ccr       (ccr)
  );

  // R5
  nz_track_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && writes_back && !ccr_wr) |=>
      (ccr[CCR_Z] == (result == '0)) &&
      (ccr[CCR_N] == ($past(size_word) ? result[WORD_W-1] : result[BYTE_W-1])));

  // R7
  cmp_no_writeback_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && op_valid && op_sel == OP_CMP) |=> !result_valid && $stable(result));

  // R9
  idle_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !arith_op && !ccr_wr && !exc_entry) |=> $stable(ccr) && !result_valid);
endmodule

// File: tb/arith_flag_unit_tb_top.sv
module arith_flag_unit_tb_top;
  typedef struct packed {
    logic [2:0]  op;
    logic        wd;
    logic        ci;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic [4:0]  fl;   // H N Z V C
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 16'h000F, 16'h0001, 16'h0010, 5'b10000},
    '{3'd0, 1'b0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 5'b11010},
    '{3'd0, 1'b0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 5'b10101},
    '{3'd1, 1'b0, 1'b1, 16'h0010, 16'h0020, 16'h0031, 5'b00000},
    '{3'd0, 1'b1, 1'b0, 16'h0F00, 16'h0100, 16'h1000, 5'b10000},
    '{3'd0, 1'b1, 1'b0, 16'h00FF, 16'h0001, 16'h0100, 5'b00000},
    '{3'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 5'b10101},
    '{3'd0, 1'b1, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 5'b11010},
    '{3'd2, 1'b0, 1'b0, 16'h0010, 16'h0001, 16'h000F, 5'b10000},
    '{3'd2, 1'b0, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 5'b11001},
    '{3'd2, 1'b0, 1'b0, 16'h0080, 16'h0001, 16'h007F, 5'b10010},
    '{3'd3, 1'b0, 1'b1, 16'h0005, 16'h0002, 16'h0002, 5'b00000},
    '{3'd3, 1'b0, 1'b1, 16'h0005, 16'h0005, 16'h00FF, 5'b11001},
    '{3'd2, 1'b1, 1'b0, 16'h1000, 16'h0001, 16'h0FFF, 5'b10000},
    '{3'd2, 1'b1, 1'b0, 16'h0010, 16'h0001, 16'h000F, 5'b00000},
    '{3'd2, 1'b1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 5'b10010},
    '{3'd4, 1'b0, 1'b0, 16'h0042, 16'h0042, 16'h7FFF, 5'b00100},
    '{3'd4, 1'b1, 1'b0, 16'h1234, 16'h2345, 16'h7FFF, 5'b11001},
    '{3'd5, 1'b0, 1'b0, 16'h0055, 16'h0001, 16'h00FF, 5'b11001},
    '{3'd5, 1'b0, 1'b0, 16'h0055, 16'h0080, 16'h0080, 5'b01011},
    '{3'd5, 1'b1, 1'b0, 16'h1234, 16'h0000, 16'h0000, 5'b00100},
    '{3'd0, 1'b0, 1'b0, 16'hAB12, 16'hCD34, 16'h0046, 5'b00000},
    '{3'd1, 1'b1, 1'b1, 16'h7FFF, 16'h0000, 16'h8000, 5'b11010},
    '{3'd2, 1'b0, 1'b0, 16'h0033, 16'h0033, 16'h0000, 5'b00100}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        size_word = 1'b0;
  logic        carry_in = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic        ccr_wr = 1'b0;
  logic [1:0]  ccr_wr_mode = '0;
  logic [7:0]  ccr_wr_data = '0;
  logic        exc_entry = 1'b0;
  logic [15:0] result;
  logic        result_valid;
  logic [7:0]  ccr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  arith_flag_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .size_word(size_word), .carry_in(carry_in), .opa(opa), .opb(opb),
    .ccr_wr(ccr_wr), .ccr_wr_mode(ccr_wr_mode), .ccr_wr_data(ccr_wr_data),
    .exc_entry(exc_entry), .result(result), .result_valid(result_valid), .ccr(ccr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; ccr_wr = 1'b0; exc_entry = 1'b0; rst = 1'b0;
  endtask

  task automatic set_op(input logic [2:0] o, input logic w, input logic c,
                        input logic [15:0] a, input logic [15:0] b);
    op_valid = 1'b1; op_sel = o; size_word = w; carry_in = c; opa = a; opb = b;
  endtask

  task automatic set_wr(input logic [1:0] m, input logic [7:0] d);
    ccr_wr = 1'b1; ccr_wr_mode = m; ccr_wr_data = d;
  endtask

  // advance one edge, then sample at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle();
    @(negedge clk);
    // R1 reset state
    check("R1 mask bit", 16'(ccr[7]), 16'h1);
    check("R1 valid", 16'(result_valid), 16'h0);
    check("R1 result", result, 16'h0000);

    // R11 known start: I=0, both user bits set
    set_wr(2'd0, 8'h50); step(); idle();
    check("R11 load", 16'(ccr), 16'h0050);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      tg = (v.op <= 3'd1) ? "R2" : (v.op <= 3'd3) ? "R3" : (v.op == 3'd4) ? "R7" : "R8";
      set_op(v.op, v.wd, v.ci, v.a, v.b);
      step();
      idle();
      check($sformatf("%s result vec%0d", tg, i), result, v.res);
      check($sformatf("%s valid vec%0d", tg, i), 16'(result_valid), (v.op == 3'd4) ? 16'h0 : 16'h1);
      // R4 R5 R6 flags, R10 I and user bits untouched
      check($sformatf("R4/R5/R6/R10 flags vec%0d", i), 16'(ccr),
            16'({2'b01, v.fl[4], 1'b1, v.fl[3:0]}));
    end

    // R11 mask writes
    set_wr(2'd0, 8'hFF); step(); idle(); check("R11 load FF", 16'(ccr), 16'h00FF);
    set_wr(2'd1, 8'h0F); step(); idle(); check("R11 and", 16'(ccr), 16'h000F);
    set_wr(2'd2, 8'h60); step(); idle(); check("R11 or", 16'(ccr), 16'h006F);
    set_wr(2'd3, 8'hFF); step(); idle(); check("R11 xor", 16'(ccr), 16'h0090);

    // R11 write wins over simultaneous flag update, result still produced
    set_wr(2'd0, 8'h50); set_op(3'd0, 1'b0, 1'b0, 16'h00FF, 16'h0001);
    step(); idle();
    check("R11 write priority ccr", 16'(ccr), 16'h0050);
    check("R11 write priority valid", 16'(result_valid), 16'h1);
    check("R11 write priority result", result, 16'h0000);

    // R12 exception with arithmetic
    set_wr(2'd0, 8'h00); step(); idle();
    exc_entry = 1'b1; set_op(3'd0, 1'b0, 1'b0, 16'h007F, 16'h0001);
    step(); idle();
    check("R12 exc with add", 16'(ccr), 16'h00AA);
    check("R12 exc add result", result, 16'h0080);

    // R12 exception beats software clear of I
    exc_entry = 1'b1; set_wr(2'd0, 8'h00); step(); idle();
    check("R12 exc over write", 16'(ccr), 16'h0080);

    // R9 reserved code
    set_op(3'd6, 1'b1, 1'b1, 16'h1234, 16'h4321); step(); idle();
    check("R9 reserved ccr", 16'(ccr), 16'h0080);
    check("R9 reserved valid", 16'(result_valid), 16'h0);
    check("R9 reserved result", result, 16'h0080);

    // R9 no op_valid
    op_sel = 3'd2; size_word = 1'b0; opa = 16'h0000; opb = 16'h0001; step();
    check("R9 idle ccr", 16'(ccr), 16'h0080);
    check("R9 idle valid", 16'(result_valid), 16'h0);

    // R1 mid-run reset with I cleared
    set_wr(2'd0, 8'h00); step(); idle();
    rst = 1'b1; step(); idle();
    check("R1 rerun mask bit", 16'(ccr[7]), 16'h1);
    check("R1 rerun result", result, 16'h0000);
    check("R1 rerun valid", 16'(result_valid), 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule